// File: doc/BRIEF.md
# SPI Flash Page-Write Command Engine

This block is the device-side logic of a serial flash that takes a page-write command over an SPI bus in mode 0. The block samples SPI data on the rising clock edge and drives it on the falling edge. The write-enable latch must be set first. A page-write frame then carries an opcode, a 24-bit address and one or more data bytes. The bytes go into a page-sized buffer, starting at the addressed offset and wrapping inside the page.

The command is accepted only when chip select returns high on a whole data byte. In that case a self-timed cycle of `WRITE_CYCLES` system clocks begins. During that cycle, only the page offsets that received data are written through a simple strobe-address-data port to an external array. The other bytes of the page are never touched, so the write alters single bytes.

A status read reports the write-in-progress and write-enable bits. A protect input per address region blocks writes to that region. All SPI pins are passed through two-stage synchronizers into the single system clock domain.

Top module: `spi_page_writer`

## Requirements
- R1: A write-enable frame (opcode 0x06, exactly 8 bits) sets the write-enable latch. A page-write frame sent while the latch is clear writes nothing.
- R2: A page-write frame is opcode 0x0A, then address bits 23..0, then data bytes, all MSB first. The page is address bits 16..8. Address bits 23..17 are ignored.
- R3: If chip select rises before the first data byte completes, or partway through a data byte, nothing is written and the write-enable latch keeps its value.
- R4: The first data byte lands at offset address[7:0]. Each following byte goes to the next offset, and offset 255 is followed by offset 0 of the same page.
- R5: When more than 256 data bytes are sent, each offset holds the last byte sent to it.
- R6: Only offsets that received data are written to the array, each exactly once per accepted command. All other bytes of the page keep their contents.
- R7: A status-read frame (opcode 0x05) returns the status byte, repeated for every further byte, MSB first. Bit 0 is write-in-progress, bit 1 is write-enable, and bits 7..2 are 0.
- R8: An accepted page-write sets write-in-progress for WRITE_CYCLES system clocks, clears the write-enable latch as the cycle starts, and then returns write-in-progress to 0.
- R9: A page-write to a region whose protect input is high writes nothing and keeps the write-enable latch. The region is address bits 16..15, which index `wp_region`.
- R10: A page-write received during a write cycle is rejected and does not change the data or page of that cycle. A write-enable received during the cycle is accepted.
- R11: After reset, the write-enable latch and write-in-progress are 0, `miso` is 0 and no array write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI clock |
| mosi | input | 1 | SPI data into the device |
| miso | output | 1 | SPI data out of the device, 0 when deselected |
| wp_region | input | REGIONS | Per-region write protect |
| mem_we | output | 1 | Array byte write strobe |
| mem_addr | output | ADDR_BITS | Array byte address |
| mem_wdata | output | 8 | Array write data |

## Verification
The bench goes after these cases:
- **Offset wrap and overrun.** It sweeps start offsets at the page ends with short bursts, and sends a 300-byte burst. A design that ran past the page or kept the first bytes of an overrun would corrupt a neighbouring page or leave stale values at the low offsets.
- **Byte-alterable writes.** It counts array strobes against the bytes sent. A design that rewrote the whole page would clobber old data.
- **Chip select timing.** It raises chip select mid-byte and after the address alone. A design that executes these frames would write garbage.
- **Rejected commands keep state.** Frames refused for protection, for a missing enable, or for a busy cycle must leave both the array and the enable latch as they were. A design that dropped this would lose or corrupt a write in progress.

// File: rtl/spi_page_writer.sv
module spi_page_writer #(
  parameter int ADDR_BITS = 17,
  parameter int OFF_BITS = 8,
  parameter int REGIONS = 4,
  parameter int WRITE_CYCLES = 300,
  parameter logic [7:0] OP_WREN = 8'h06,
  parameter logic [7:0] OP_RDSR = 8'h05,
  parameter logic [7:0] OP_PW = 8'h0A
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 sclk,
  input  logic                 mosi,
  output logic                 miso,
  input  logic [REGIONS-1:0]   wp_region,
  output logic                 mem_we,
  output logic [ADDR_BITS-1:0] mem_addr,
  output logic [7:0]           mem_wdata
);
  localparam int PAGE_BYTES = 1 << OFF_BITS;
  localparam int RBITS = $clog2(REGIONS);
  localparam int CW = $clog2(WRITE_CYCLES) + 1;
  localparam int PB = ADDR_BITS - OFF_BITS;

  logic [2:0] cs_q, ck_q;
  logic [1:0] di_q;
  logic [2:0] bit_i, nbytes;
  logic [6:0] sh, tx;
  logic [7:0] opcode;
  logic [ADDR_BITS-1:0] addr;
  logic [OFF_BITS-1:0] woff;
  logic [PB-1:0] page;
  logic [7:0] pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask;
  logic wel, busy, miso_r;
  logic [CW-1:0] cnt;

  wire sel    = !cs_q[1];
  wire rise   = sel && ck_q[1] && !ck_q[2];
  wire fall   = sel && !ck_q[1] && ck_q[2];
  wire cs_up  = cs_q[1] && !cs_q[2];
  wire cs_dn  = sel && cs_q[2];
  wire [7:0] byte_in = {sh, di_q[1]};
  wire byte_done = rise && bit_i == 3'd7;
  wire store = byte_done && nbytes >= 3'd4 && opcode == OP_PW && !busy;
  wire [RBITS-1:0] region = addr[ADDR_BITS-1 -: RBITS];
  wire pw_ok = cs_up && !busy && wel && opcode == OP_PW && nbytes == 3'd5
               && bit_i == 3'd0 && !wp_region[region];
  wire wren_ok = cs_up && opcode == OP_WREN && nbytes == 3'd1 && bit_i == 3'd0;
  wire [7:0] status = {6'b0, wel, busy};
  wire [OFF_BITS-1:0] cidx = cnt[OFF_BITS-1:0];

  assign miso      = miso_r;
  assign mem_we    = busy && int'(cnt) < PAGE_BYTES && mask[cidx];
  assign mem_addr  = {page, cidx};
  assign mem_wdata = pbuf[cidx];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q <= 3'b111; ck_q <= '0; di_q <= '0;
    end else begin
      cs_q <= {cs_q[1:0], cs_n};
      ck_q <= {ck_q[1:0], sclk};
      di_q <= {di_q[0], mosi};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_i <= '0; nbytes <= '0; sh <= '0; opcode <= '0; addr <= '0;
    end else if (!sel) begin
      bit_i <= '0; nbytes <= '0;
    end else if (rise) begin
      sh <= byte_in[6:0];
      bit_i <= bit_i + 3'd1;
      if (bit_i == 3'd7) begin
        if (nbytes != 3'd5) nbytes <= nbytes + 3'd1;
        if (nbytes == 3'd0) opcode <= byte_in;
        if (nbytes >= 3'd1 && nbytes <= 3'd3 && !busy)
          addr <= {addr[ADDR_BITS-9:0], byte_in};
      end
    end

  always_ff @(posedge clk)
    if (store) pbuf[woff] <= byte_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask <= '0; woff <= '0; page <= '0;
    end else begin
      if (cs_dn && !busy) mask <= '0;
      if (byte_done && nbytes == 3'd3 && !busy) woff <= byte_in[OFF_BITS-1:0];
      if (store) begin
        mask[woff] <= 1'b1;
        woff <= woff + 1'b1;
      end
      if (pw_ok) page <= addr[ADDR_BITS-1:OFF_BITS];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wel <= 1'b0; busy <= 1'b0; cnt <= '0;
    end else begin
      if (pw_ok) wel <= 1'b0;
      else if (wren_ok) wel <= 1'b1;
      if (pw_ok) begin
        busy <= 1'b1; cnt <= '0;
      end else if (busy) begin
        if (cnt == CW'(WRITE_CYCLES - 1)) busy <= 1'b0;
        cnt <= cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      miso_r <= 1'b0; tx <= '0;
    end else if (!sel) begin
      miso_r <= 1'b0;
    end else if (fall && opcode == OP_RDSR && nbytes != 3'd0) begin
      if (bit_i == 3'd0) begin
        miso_r <= status[7]; tx <= status[6:0];
      end else begin
        miso_r <= tx[6]; tx <= {tx[5:0], 1'b0};
      end
    end

  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel)); // R1
  AST_START_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cs_q[1]); // R3
  AST_WEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !wel); // R8
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(page)); // R10
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(mask)); // R10
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we); // R11
endmodule

// File: tb/sim_spi_page_writer.sv
module sim_spi_page_writer;
  localparam int WC = 1000;
  localparam int HALF = 5;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic [3:0] wp = '0;
  logic miso, mem_we;
  logic [16:0] mem_addr;
  logic [7:0] mem_wdata;

  always #5 clk = ~clk;

  spi_page_writer #(.WRITE_CYCLES(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .wp_region(wp), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata));

  logic [7:0] bmem [int];
  logic [7:0] emem [int];
  int we_cnt = 0, checks = 0, fails = 0, base;
  bit done = 1'b0;

  always @(posedge clk) if (mem_we) begin
    bmem[int'(mem_addr)] = mem_wdata;
    we_cnt++;
  end

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] dat(input int s, input int k);
    return 8'((s * 37 + k * 11 + (k >> 8) * 5) & 255);
  endfunction

  task automatic nbits(input logic [7:0] b, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = b[i]; tick(HALF);
      sclk = 1'b1; r[i] = miso; tick(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] b);
    logic [7:0] r;
    nbits(b, 8, r);
  endtask

  task automatic sel();
    cs_n = 1'b0; tick(HALF);
  endtask

  task automatic desel();
    tick(HALF); cs_n = 1'b1; tick(2 * HALF);
  endtask

  task automatic wren();
    sel(); xfer(8'h06); desel();
  endtask

  task automatic rdsr(output logic [7:0] s, output logic [7:0] s2);
    logic [7:0] r;
    sel(); nbits(8'h05, 8, r); nbits(8'h00, 8, s); nbits(8'h00, 8, s2); desel();
  endtask

  task automatic stat(input string rq, input int exp);
    logic [7:0] s, s2;
    rdsr(s, s2);
    chk(rq, s, exp);
  endtask

  task automatic pw(input logic [23:0] a, input int seed, input int n, input bit acc);
    sel(); xfer(8'h0A); xfer(a[23:16]); xfer(a[15:8]); xfer(a[7:0]);
    for (int k = 0; k < n; k++) xfer(dat(seed, k));
    desel();
    if (acc)
      for (int k = 0; k < n; k++)
        emem[int'(a[16:8]) * 256 + ((int'(a[7:0]) + k) & 255)] = dat(seed, k);
  endtask

  task automatic wait_idle();
    repeat (WC + 100) @(negedge clk);
  endtask

  task automatic check_page(input int pg, input string rq);
    int mism = 0, first = -1;
    logic [7:0] g, e;
    for (int i = 0; i < 256; i++) begin
      g = bmem.exists(pg * 256 + i) ? bmem[pg * 256 + i] : 8'h00;
      e = emem.exists(pg * 256 + i) ? emem[pg * 256 + i] : 8'h00;
      if (g !== e) begin
        mism++;
        if (first < 0) first = i;
      end
    end
    if (mism != 0) $display("page %0d first bad offset %0d", pg, first);
    chk(rq, mism, 0);
  endtask

  initial begin
    logic [7:0] s, s2, r;
    tick(4); rst_n = 1'b1; tick(4);
    chk("R11 miso idle", miso, 0);
    stat("R11 status after reset", 8'h00);
    chk("R11 no writes", we_cnt, 0);

    base = we_cnt; pw({7'h0, 9'd5, 8'h00}, 1, 4, 1'b0); wait_idle();
    chk("R1 no write without enable", we_cnt - base, 0);
    check_page(5, "R1");

    wren();
    rdsr(s, s2);
    chk("R1 enable latch set", s, 8'h02);
    chk("R7 status repeats", s2, 8'h02);

    base = we_cnt; pw({7'h0, 9'd5, 8'h00}, 2, 256, 1'b1);
    stat("R8 busy and latch cleared", 8'h01);
    wait_idle();
    stat("R8 cycle finished", 8'h00);
    chk("R6 full page strobes", we_cnt - base, 256);
    check_page(5, "R2");

    wren(); base = we_cnt; pw({7'h0, 9'd5, 8'd250}, 3, 10, 1'b1); wait_idle();
    chk("R6 partial strobes", we_cnt - base, 10);
    check_page(5, "R4");

    wren(); base = we_cnt; pw({7'h0, 9'd6, 8'd16}, 4, 300, 1'b1); wait_idle();
    chk("R5 overrun strobes", we_cnt - base, 256);
    check_page(6, "R5");

    wren(); base = we_cnt;
    sel(); xfer(8'h0A); xfer(8'h00); xfer(8'h07); xfer(8'h00);
    xfer(8'h11); xfer(8'h22); nbits(8'hFF, 3, r); desel(); wait_idle();
    chk("R3 mid-byte deselect", we_cnt - base, 0);
    sel(); xfer(8'h0A); xfer(8'h00); xfer(8'h07); xfer(8'h00); desel(); wait_idle();
    chk("R3 no data byte", we_cnt - base, 0);
    stat("R3 latch kept", 8'h02);
    check_page(7, "R3");

    wp = 4'b0010; base = we_cnt;
    pw({7'h0, 9'd130, 8'h00}, 5, 8, 1'b0); wait_idle();
    chk("R9 protected region", we_cnt - base, 0);
    stat("R9 latch kept", 8'h02);
    pw({7'h0, 9'd5, 8'd100}, 6, 3, 1'b1); wait_idle();
    chk("R9 open region written", we_cnt - base, 3);
    check_page(5, "R9");
    check_page(130, "R9");
    wp = '0;

    wren(); base = we_cnt; pw({7'h7F, 9'd9, 8'h20}, 7, 4, 1'b1); wait_idle();
    chk("R2 upper bits ignored", we_cnt - base, 4);
    check_page(9, "R2");

    wren(); base = we_cnt; pw({7'h0, 9'd10, 8'h00}, 8, 256, 1'b1);
    wren(); pw({7'h0, 9'd11, 8'h00}, 9, 1, 1'b0); wait_idle();
    stat("R10 enable accepted while busy", 8'h02);
    chk("R10 strobes", we_cnt - base, 256);
    check_page(10, "R10");
    check_page(11, "R10");

    for (int oi = 0; oi < 4; oi++)
      for (int n = 1; n <= 3; n++) begin
        int off = (oi == 0) ? 0 : (oi == 1) ? 1 : (oi == 2) ? 128 : 255;
        int pg = 20 + oi;
        wren(); base = we_cnt;
        pw({7'h0, 9'(pg), 8'(off)}, 10 + n, n, 1'b1); wait_idle();
        chk("R6 sweep strobes", we_cnt - base, n);
        check_page(pg, "R4");
      end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule